// File: doc/BRIEF.md
# Free-Running Link Merger and Packet Framer

This block gathers 64-bit words from several front-end chip links while the readout runs without a trigger, and packs them into byte packets for a datagram transmitter downstream. Each link offers words on a valid/ready handshake, together with a flag that marks the periodic time-frame words the front-end inserts as a time reference. Only links whose bit is set in the enable mask take part. Enabled links are served in rotation, one whole word at a time, and each word leaves as eight bytes with the most significant byte first.

A packet ends when either of two things happens. The first is that the eighth time-frame word from the reference link has been packed. The second is that the packet holds 180 words, which is 1440 bytes and so fits a standard 1500-byte payload. Words that arrive after a word-count closure go into the next packet. The time-frame count is not cleared by a word-count closure, so that next packet still ends on the original eighth-frame boundary. The output marks the first and last byte of every packet. Header insertion and the network MAC belong to later stages.

Top module: `trigless_pkt_agg`

## Requirements
- R1: While reset is held and no link offers a word, `out_valid` is low and no `lnk_ready` bit is high. After reset is released with all `lnk_valid` low, both stay low.
- R2: A link whose `lnk_en` bit is 0 never sees `lnk_ready` high. Its words are never consumed and never appear on the output.
- R3: At most one `lnk_ready` bit is high at a time, and only while the output can take a new word. The granted link is the first enabled, valid link found by searching upward from the last granted index, wrapping around. After reset, link 0 has first priority.
- R4: Each accepted word is sent as 8 consecutive output bytes, bits 63:56 first and bits 7:0 last. Bytes of different words are never interleaved.
- R5: `out_first` is high only on the first byte of the first word of a packet. `out_last` is high only on the last byte of the word that closes the packet.
- R6: A word whose `lnk_frame` bit is 1 counts as a time frame only when it comes from the reference link, which is the lowest-numbered enabled link. The word that brings the count to 8 closes the packet as its last word, and the frame count restarts at 0.
- R7: The word that brings the packet's word count to 180 closes the packet. Any later word starts the next packet, so no packet exceeds 1440 bytes, which is within 1500.
- R8: A closure by word count leaves the frame count unchanged. The following packet therefore closes when the total number of reference frames reaches 8.
- R9: While `out_valid` is high and `out_ready` is low, `out_byte`, `out_first` and `out_last` hold their values and `out_valid` stays high.
- R10: A new word can be accepted in the same cycle as the last byte of the previous word is taken. With constant valid input and constant `out_ready`, the output carries one byte every cycle with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lnk_en | input | N_LINKS | Per-link participation mask |
| lnk_valid | input | N_LINKS | Per-link word offered |
| lnk_ready | output | N_LINKS | Per-link word accepted this cycle |
| lnk_frame | input | N_LINKS | Per-link flag: offered word is a time-frame word |
| lnk_word | input | N_LINKS*64 | Per-link word, link i in bits i*64+63 down to i*64 |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Output byte |
| out_first | output | 1 | First byte of a packet |
| out_last | output | 1 | Last byte of a packet |

## Verification
The bench targets four corner cases.

- Frame words on a link that is enabled but is not the reference. If a design counted them, the 20 frames on link 3 would close a packet that must stay open.
- A word-count closure followed by further frames. A design that cleared the frame count at that closure would give a second packet much longer than the expected 20 words.
- Disabled links that keep offering words. A leak would show up as a ready pulse, a foreign byte in the stream, or a shorter queue on that link.
- Full-rate streaming. Any bubble at a word boundary stretches the span of 128 bytes beyond 128 cycles.

Random backpressure and random input gaps exercise the rotation order and stall holding against the cycle model.

// File: rtl/tla_pkg.sv
// Shared types and helpers for the trigger-less link merger.
// Assumes index arithmetic stays below twice the link count.
package tla_pkg;

    // Packet position tags carried along with each accepted word
    typedef struct packed {
        logic first;
        logic last;
    } wtag_t;

    // Modular add for rotating indices: base < n and off <= n
    function automatic int wrap_add(input int base, input int off, input int n);
        int s;
        s = base + off;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/tla_rr_arb.sv
// Rotating-priority arbiter. It grants the first requester above the last
// granted index, wrapping around. The pointer moves only when a grant is
// actually used (advance). Assumes N >= 2.
module tla_rr_arb
    import tla_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          advance,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] gnt_idx
);

    logic [IW-1:0] last_q;
    int            cand;

    // Search upward from the last granted index for the first requester
    always_comb begin
        gnt     = '0;
        gnt_idx = last_q;
        cand    = 0;
        for (int k = 1; k <= N; k++) begin
            cand = wrap_add(int'(last_q), k, N);
            if (gnt == '0 && req[cand]) begin
                gnt[cand] = 1'b1;
                gnt_idx   = IW'(cand);
            end
        end
    end

    // Remember the last served link; reset makes link 0 first in line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IW'(N - 1);
        end else if (advance) begin
            last_q <= gnt_idx;
        end
    end

endmodule

// File: rtl/tla_pkt_ctrl.sv
// Packet boundary control. It counts the words in the current packet and
// the time frames seen on the reference link, which is the lowest enabled
// link. It tags each accepted word as first and/or last of a packet.
// A word-count closure keeps the frame count running.
module tla_pkt_ctrl
    import tla_pkg::*;
#(
    parameter int N      = 4,
    parameter int FRAMES = 8,
    parameter int WORDS  = 180,
    localparam int IW  = (N > 1) ? $clog2(N) : 1,
    localparam int WCW = $clog2(WORDS + 1),
    localparam int FCW = $clog2(FRAMES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  en,
    input  logic          accept,
    input  logic [IW-1:0] src_idx,
    input  logic          src_frame,
    output wtag_t         tag
);

    logic [WCW-1:0] wcnt_q;
    logic [FCW-1:0] fcnt_q;
    logic [IW-1:0]  ref_idx;
    logic           is_ref_frame;
    logic           close_frame;
    logic           close_words;

    // Pick the lowest enabled link as the time reference
    always_comb begin
        ref_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (en[i]) ref_idx = IW'(i);
        end
    end

    // Decide the tags of the word being accepted this cycle
    always_comb begin
        is_ref_frame = src_frame && (src_idx == ref_idx);
        close_frame  = is_ref_frame && (fcnt_q == FCW'(FRAMES - 1));
        close_words  = (wcnt_q == WCW'(WORDS - 1));
        tag.first    = (wcnt_q == '0);
        tag.last     = close_frame || close_words;
    end

    // Advance the word and frame counters on each accepted word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            fcnt_q <= '0;
        end else if (accept) begin
            wcnt_q <= tag.last ? '0 : wcnt_q + 1'b1;
            if (close_frame) begin
                fcnt_q <= '0;
            end else if (is_ref_frame) begin
                fcnt_q <= fcnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tla_word_ser.sv
// Word-to-byte serializer with one word of storage. It sends the most
// significant byte first and holds its output while stalled. It reports
// can_load so a new word can enter in the cycle its last byte is taken.
module tla_word_ser
    import tla_pkg::*;
#(
    parameter int WB = 8,
    localparam int WW = WB * 8,
    localparam int BW = (WB > 1) ? $clog2(WB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [WW-1:0] word,
    input  wtag_t         tag,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [7:0]    out_byte,
    output logic          out_first,
    output logic          out_last,
    output logic          can_load
);

    logic [WW-1:0] sreg_q;
    logic [BW-1:0] idx_q;
    logic          busy_q;
    wtag_t         tag_q;
    logic          at_end;
    logic          take;

    // Handshake and slot status
    always_comb begin
        at_end   = (idx_q == BW'(WB - 1));
        take     = busy_q && out_ready;
        can_load = !busy_q || (out_ready && at_end);
    end

    // Load a new word or shift out the byte just taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
            tag_q  <= '0;
        end else if (load) begin
            sreg_q <= word;
            idx_q  <= '0;
            busy_q <= 1'b1;
            tag_q  <= tag;
        end else if (take) begin
            sreg_q <= sreg_q << 8;
            idx_q  <= at_end ? '0 : idx_q + 1'b1;
            if (at_end) busy_q <= 1'b0;
        end
    end

    // Present the top byte with packet markers on the edge bytes
    always_comb begin
        out_valid = busy_q;
        out_byte  = sreg_q[WW-1 -: 8];
        out_first = busy_q && tag_q.first && (idx_q == '0);
        out_last  = busy_q && tag_q.last && at_end;
    end

endmodule

// File: rtl/trigless_pkt_agg.sv
// Trigger-less packet aggregator. It merges words from the enabled links
// in rotation into a byte packet stream. A packet closes on the eighth
// reference time frame or at the word limit, whichever comes first.
// Assumes N_LINKS >= 2 and that each link's word and flags stay steady
// while its valid is high in a cycle.
module trigless_pkt_agg
    import tla_pkg::*;
#(
    parameter int N_LINKS        = 4,
    parameter int WORD_BYTES     = 8,
    parameter int FRAMES_PER_PKT = 8,
    parameter int WORDS_PER_PKT  = 180,
    parameter int MAX_PKT_BYTES  = 1500
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_LINKS-1:0]            lnk_en,
    input  logic [N_LINKS-1:0]            lnk_valid,
    output logic [N_LINKS-1:0]            lnk_ready,
    input  logic [N_LINKS-1:0]            lnk_frame,
    input  logic [N_LINKS*WORD_BYTES*8-1:0] lnk_word,
    output logic                          out_valid,
    input  logic                          out_ready,
    output logic [7:0]                    out_byte,
    output logic                          out_first,
    output logic                          out_last
);

    localparam int WW = WORD_BYTES * 8;
    localparam int IW = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;

    logic [WW-1:0]      word_arr [N_LINKS];
    logic [N_LINKS-1:0] req;
    logic [N_LINKS-1:0] gnt;
    logic [IW-1:0]      gnt_idx;
    logic               can_load;
    logic               accept;
    logic [WW-1:0]      sel_word;
    logic               sel_frame;
    wtag_t              tag;

    // Split the flat word bus into one word per link
    for (genvar g = 0; g < N_LINKS; g++) begin : g_unpack
        assign word_arr[g] = lnk_word[g*WW +: WW];
    end

    // Requests come only from enabled links; a grant is used only when the serializer has room
    always_comb begin
        req       = lnk_valid & lnk_en;
        lnk_ready = gnt & {N_LINKS{can_load}};
        accept    = |lnk_ready;
        sel_word  = word_arr[gnt_idx];
        sel_frame = lnk_frame[gnt_idx];
    end

    tla_rr_arb #(.N(N_LINKS)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .advance (accept),
        .gnt     (gnt),
        .gnt_idx (gnt_idx)
    );

    tla_pkt_ctrl #(
        .N      (N_LINKS),
        .FRAMES (FRAMES_PER_PKT),
        .WORDS  (WORDS_PER_PKT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (lnk_en),
        .accept    (accept),
        .src_idx   (gnt_idx),
        .src_frame (sel_frame),
        .tag       (tag)
    );

    tla_word_ser #(.WB(WORD_BYTES)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .word      (sel_word),
        .tag       (tag),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_byte  (out_byte),
        .out_first (out_first),
        .out_last  (out_last),
        .can_load  (can_load)
    );

endmodule

// File: rtl/tla_checker.sv
// Property checker for the trigger-less aggregator. It is attached to
// every instance of the top by the bind at the end of this file.
module tla_checker #(
    parameter int N_LINKS       = 4,
    parameter int WORD_BYTES    = 8,
    parameter int WORDS_PER_PKT = 180,
    parameter int MAX_PKT_BYTES = 1500
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_LINKS-1:0] lnk_en,
    input logic [N_LINKS-1:0] lnk_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [7:0]         out_byte,
    input logic               out_first,
    input logic               out_last
);

    localparam int LIMIT_BYTES = WORDS_PER_PKT * WORD_BYTES;

    logic [15:0] pkt_bytes_q;
    logic        expect_first_q;
    logic        hs;

    assign hs = out_valid && out_ready;

    // Track the bytes in the open packet and whether the next byte starts a packet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_bytes_q    <= '0;
            expect_first_q <= 1'b1;
        end else if (hs) begin
            pkt_bytes_q    <= out_last ? 16'd0 : pkt_bytes_q + 16'd1;
            expect_first_q <= out_last;
        end
    end

    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lnk_ready)); // R3

    AST_DISABLED_NEVER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_ready & ~lnk_en) == '0); // R2

    AST_ACCEPT_NEEDS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (|lnk_ready) |-> (!out_valid || out_ready)); // R10

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)
                                        && $stable(out_first) && $stable(out_last))); // R9

    AST_FIRST_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        hs |-> (out_first == expect_first_q)); // R5

    AST_PKT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hs |-> (int'(pkt_bytes_q) < LIMIT_BYTES && int'(pkt_bytes_q) < MAX_PKT_BYTES)); // R7

endmodule

bind trigless_pkt_agg tla_checker #(
    .N_LINKS       (N_LINKS),
    .WORD_BYTES    (WORD_BYTES),
    .WORDS_PER_PKT (WORDS_PER_PKT),
    .MAX_PKT_BYTES (MAX_PKT_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lnk_en    (lnk_en),
    .lnk_ready (lnk_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_first (out_first),
    .out_last  (out_last)
);

// File: tb/tb_trigless_pkt_agg.sv
// Bench for the trigger-less aggregator: a behavioural queue model,
// compared with the design on every clock.
module tb_trigless_pkt_agg;

    localparam int N   = 4;
    localparam int WB  = 8;
    localparam int FPP = 8;
    localparam int WPP = 180;

    typedef struct {
        logic [7:0] b;
        logic       f;
        logic       l;
    } ob_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N-1:0]     lnk_en = '0;
    logic [N-1:0]     lnk_valid = '0;
    logic [N-1:0]     lnk_ready;
    logic [N-1:0]     lnk_frame = '0;
    logic [N*64-1:0]  lnk_word = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [7:0]       out_byte;
    logic             out_first;
    logic             out_last;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [64:0] lq [N][$];   // bit 64 = frame flag, 63:0 = word
    ob_t         mq [$];      // expected output bytes
    int          mptr;        // last granted link
    int          mw;          // words in open packet
    int          mf;          // reference frames counted
    int          pkt_len [$]; // observed packet lengths in words
    int          obytes;      // observed bytes in open packet
    int          hs_first, hs_last, hs_count;

    trigless_pkt_agg dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lnk_en    (lnk_en),
        .lnk_valid (lnk_valid),
        .lnk_ready (lnk_ready),
        .lnk_frame (lnk_frame),
        .lnk_word  (lnk_word),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_byte  (out_byte),
        .out_first (out_first),
        .out_last  (out_last)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R1..R10 watchdog: actual cycles %0d expected fewer than 190000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    function automatic int ref_link();
        for (int i = 0; i < N; i++) if (lnk_en[i]) return i;
        return 0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lnk_valid = '0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0 && lnk_ready == '0, "R1", "reset quiet",
              {out_valid, lnk_ready}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0 && lnk_ready == '0, "R1", "post-reset quiet",
              {out_valid, lnk_ready}, 0);
        mq.delete();
        pkt_len.delete();
        mptr = N - 1;
        mw = 0;
        mf = 0;
        obytes = 0;
        hs_first = -1;
        hs_last = -1;
        hs_count = 0;
    endtask

    // One clock: drive inputs, compare with the model, advance the model
    task automatic step(input int vprob, input int rprob);
        logic [N-1:0] exp_ready;
        bit slot;
        int g;
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            if (lq[i].size() > 0 && $urandom_range(99) < vprob) begin
                lnk_valid[i] = 1'b1;
                lnk_word[i*64 +: 64] = lq[i][0][63:0];
                lnk_frame[i] = lq[i][0][64];
            end else begin
                lnk_valid[i] = 1'b0;
                lnk_frame[i] = 1'b0;
            end
        end
        out_ready = ($urandom_range(99) < rprob);
        #1;
        exp_ready = '0;
        g = -1;
        slot = (mq.size() == 0) || (mq.size() == 1 && out_ready);
        if (slot) begin
            for (int k = 1; k <= N; k++) begin
                int c;
                c = (mptr + k) % N;
                if (g < 0 && lnk_en[c] && lnk_valid[c]) begin
                    g = c;
                    exp_ready[c] = 1'b1;
                end
            end
        end
        if ((lnk_ready & ~lnk_en) != '0)
            check(0, "R2", "disabled link ready", lnk_ready, exp_ready);
        else
            check(lnk_ready == exp_ready, "R3", "ready vector", lnk_ready, exp_ready);
        check(out_valid == (mq.size() > 0), "R4", "out_valid", out_valid, mq.size() > 0);
        if (mq.size() > 0 && out_valid) begin
            check(out_byte == mq[0].b, "R4", "byte value", out_byte, mq[0].b);
            check(out_first == mq[0].f, "R5", "first marker", out_first, mq[0].f);
            check(out_last == mq[0].l, "R5", "last marker", out_last, mq[0].l);
        end
        // Observed packet statistics from the design's own outputs
        if (out_valid && out_ready) begin
            if (hs_first < 0) hs_first = cyc;
            hs_last = cyc;
            hs_count++;
            obytes++;
            if (out_last) begin
                pkt_len.push_back(obytes / WB);
                obytes = 0;
            end
        end
        // Advance the model
        if (mq.size() > 0 && out_ready) void'(mq.pop_front());
        if (g >= 0) begin
            logic [64:0] e;
            bit isref, lst, fst;
            e = lq[g].pop_front();
            isref = e[64] && (g == ref_link());
            fst = (mw == 0);
            lst = (isref && mf == FPP - 1) || (mw == WPP - 1);
            if (isref) mf = (mf == FPP - 1) ? 0 : mf + 1;
            mw = lst ? 0 : mw + 1;
            for (int j = 0; j < WB; j++) begin
                ob_t o;
                o.b = e[63 - 8*j -: 8];
                o.f = fst && (j == 0);
                o.l = lst && (j == WB - 1);
                mq.push_back(o);
            end
            mptr = g;
        end
    endtask

    task automatic drain(input int vprob, input int rprob);
        int guard = 0;
        bit busy = 1;
        while (busy && guard < 30000) begin
            step(vprob, rprob);
            guard++;
            busy = (mq.size() > 0);
            for (int i = 0; i < N; i++) if (lnk_en[i] && lq[i].size() > 0) busy = 1;
        end
        check(guard < 30000, "R3", "drain finished", guard, 30000);
        @(negedge clk);
        lnk_valid = '0;
    endtask

    function automatic logic [64:0] mk(input int link, input int seq, input bit fr);
        return {fr, 8'hA0 + 8'(link), 24'(seq), 32'hC3D2E1F0 ^ 32'(seq * 7 + link)};
    endfunction

    initial begin
        for (int i = 0; i < N; i++) lq[i].delete();

        // A: four links, no frames, random flow; one word-limit packet (R7, R3, R4)
        do_reset();
        lnk_en = 4'b1111;
        for (int i = 0; i < N; i++)
            for (int s = 0; s < 50; s++) lq[i].push_back(mk(i, s, 0));
        drain(70, 60);
        check(pkt_len.size() == 1, "R7", "packet count at word limit", pkt_len.size(), 1);
        if (pkt_len.size() > 0)
            check(pkt_len[0] == WPP, "R7", "packet length", pkt_len[0], WPP);

        // B: one link, all frame words, full rate (R6, R10)
        do_reset();
        lnk_en = 4'b0001;
        for (int s = 0; s < 16; s++) lq[0].push_back(mk(0, s, 1));
        drain(100, 100);
        check(pkt_len.size() == 2, "R6", "frame-closed packets", pkt_len.size(), 2);
        if (pkt_len.size() == 2)
            check(pkt_len[0] == 8 && pkt_len[1] == 8, "R6", "frame packet lengths",
                  {pkt_len[0], pkt_len[1]}, {32'd8, 32'd8});
        check(hs_count == 128 && hs_last - hs_first == 127, "R10", "byte span cycles",
              hs_last - hs_first, 127);

        // C: mask 1010; disabled links loaded; link 3 frames not counted (R2, R6)
        do_reset();
        lnk_en = 4'b1010;
        for (int s = 0; s < 10; s++) lq[0].push_back(mk(0, s, 1));
        for (int s = 0; s < 10; s++) lq[2].push_back(mk(2, s, 0));
        for (int s = 0; s < 20; s++) lq[1].push_back(mk(1, s, (s % 3) == 2));
        for (int s = 0; s < 20; s++) lq[3].push_back(mk(3, s, 1));
        drain(80, 70);
        check(lq[0].size() == 10 && lq[2].size() == 10, "R2", "disabled queues untouched",
              lq[0].size() + lq[2].size(), 20);
        check(pkt_len.size() == 0, "R6", "non-reference frames ignored", pkt_len.size(), 0);
        for (int i = 0; i < N; i++) lq[i].delete();

        // D: frame count carried across a word-limit closure (R8)
        do_reset();
        lnk_en = 4'b0001;
        for (int s = 0; s < WPP; s++) lq[0].push_back(mk(0, s, s == 10 || s == 20 || s == 30));
        for (int s = 0; s < 40; s++) lq[0].push_back(mk(0, 1000 + s, (s % 4) == 3));
        drain(80, 50);
        check(pkt_len.size() == 2, "R8", "packet count", pkt_len.size(), 2);
        if (pkt_len.size() == 2) begin
            check(pkt_len[0] == WPP, "R7", "first packet by word limit", pkt_len[0], WPP);
            check(pkt_len[1] == 20, "R8", "second packet ends on eighth frame", pkt_len[1], 20);
        end

        // E: three links, sparse frames, heavy backpressure (R3, R4, R5, R9)
        do_reset();
        lnk_en = 4'b0111;
        for (int i = 0; i < 3; i++)
            for (int s = 0; s < 120; s++)
                lq[i].push_back(mk(i, s, $urandom_range(9) == 0));
        drain(60, 40);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule